// File: doc/BRIEF.md
# Self-Timed Byte Write Engine with Completion Polling

This block is a clocked model of the write path of a byte-wide nonvolatile memory. The host sees a static-RAM-like port with an active-low chip select, an active-low output enable, an active-low write strobe, an address and a data bus. The data bus is split into an input, an output and an output drive-enable. All control pins are sampled on the system clock. A write pulse captures one address and one data byte. After the pulse ends, the block runs on its own counter: it first erases the target byte to all ones and then programs the captured value. The host does nothing more during that time.

The host can detect completion in two ways. The first is a shared completion line. It is pulled low for the whole write and then released, so that several devices can be wired together on one line. The second is a read during the write, which returns the inverse of the most significant bit of the byte being written. Writes are locked out while the supply-good input is low, and for a settling period after it rises. The write time takes one of two values, standard or fast, and a parameter picks between them.

Top module: `nvbyte_wr_engine`

## Requirements
- R1: A write pulse is the interval in which chip select and write strobe are both low (value 0) and output enable is high. The address is captured in the first cycle of the pulse. The data is captured in the cycle in which the pulse ends, so changes on either bus in mid-pulse move the address not at all and the data to its last value.
- R2: The engine goes busy in the cycle after a captured pulse ends. It erases the target byte to all ones, then programs the captured byte, with no further host action. If reset arrives in mid-write, the byte is left erased (all ones).
- R3: Busy lasts exactly WC_STD_CYC clock cycles when FAST_SEL is 0, and exactly WC_FAST_CYC cycles when FAST_SEL is 1.
- R4: While busy, an enabled read drives dat_o[DATA_W-1] as the inverse of the most significant bit of the byte being written, and dat_o[DATA_W-2:0] as zero, at any address.
- R5: In the first cycle after busy ends, a read of the written address returns the full written byte.
- R6: While busy, done_line is 0 and done_line_drv is 1. While idle, done_line is 1 and done_line_drv is 0 (released).
- R7: A pulse with output enable low, or with chip select held high, starts no write and changes no stored byte.
- R8: No write starts while pwr_ok is 0, or within POR_CYC cycles after pwr_ok rises.
- R9: dat_oe is 1 only when chip select and output enable are low and the write strobe is high.
- R10: A new write pulse that arrives while busy is ignored. It does not lengthen the busy period, and it changes neither the captured address nor the captured data.
- R11: Reset clears busy (done_line 1, done_line_drv 0) and restarts the POR_CYC lockout. It keeps the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good indication; 0 blocks writes |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Byte address |
| dat_i | input | DATA_W | Write data from host |
| dat_o | output | DATA_W | Read data, or the polling word while busy |
| dat_oe | output | 1 | Drive-enable for dat_o |
| done_line | output | 1 | Completion line value: 0 while busy |
| done_line_drv | output | 1 | Completion line drive-enable (open-drain model) |

## Verification
The assertions assume that a write pulse stays shorter than the busy window that follows it. They also assume that pwr_ok and the control pins change only once per cycle, so that a pulse edge is seen at one clock edge. The stimulus changes inputs only on the falling clock edge. It keeps every pulse a few cycles long, and every pulse sent during a busy period rises and ends well inside that period. For the fast variant, the bench uses a second instance with a shorter write time. It measures that instance in the same window as the first, and relies on the fast write ending before the standard one.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CLEAR = 2'd1,
    SQ_PROG  = 2'd2
  } sq_state_t;

  // Write pulse: select and strobe low, output enable high.
  function automatic logic wr_pulse_on(input logic cs_n, input logic oe_n, input logic wr_n);
    return !cs_n && !wr_n && oe_n;
  endfunction

  // Read drive: select and output enable low, strobe high.
  function automatic logic rd_drive_on(input logic cs_n, input logic oe_n, input logic wr_n);
    return !cs_n && !oe_n && wr_n;
  endfunction

  // Write cycle length in clocks for the chosen option.
  function automatic int unsigned pick_wc(input int unsigned std_c, input int unsigned fast_c,
                                          input bit fast);
    return fast ? fast_c : std_c;
  endfunction

endpackage

// File: rtl/nvw_power.sv
module nvw_power #(
  parameter int unsigned POR_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  output logic wr_allow
);
  localparam int unsigned PW = $clog2(POR_CYC + 1);
  localparam logic [PW-1:0] POR_END = PW'(POR_CYC);

  logic [PW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok) begin
      settle_cnt <= '0;
    end else if (settle_cnt != POR_END) begin
      settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign wr_allow = pwr_ok && (settle_cnt == POR_END);
endmodule

// File: rtl/nvw_strobe.sv
module nvw_strobe #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              wr_allow,
  input  logic              busy,
  output logic              start_ev,
  output logic              end_ev,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data
);
  logic pulse_now, pulse_q, pend;

  assign pulse_now = nvw_pkg::wr_pulse_on(cs_n, oe_n, wr_n);
  assign start_ev  = pulse_now && !pulse_q && wr_allow && !busy;
  assign end_ev    = !pulse_now && pulse_q && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q  <= 1'b0;
      pend     <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      pulse_q <= pulse_now;
      if (start_ev) begin
        pend     <= 1'b1;
        lat_addr <= addr_i;
      end else if (end_ev) begin
        pend <= 1'b0;
      end
      if (end_ev) begin
        lat_data <= dat_i;
      end
    end
  end
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WC_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              end_ev,
  input  logic [DATA_W-1:0] lat_data,
  output logic              busy,
  output logic              arr_we,
  output logic [DATA_W-1:0] arr_wdata
);
  import nvw_pkg::*;

  localparam int unsigned CW = $clog2(WC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WC_CYC - 1);

  sq_state_t     state;
  logic [CW-1:0] tick;
  logic          prog_done;

  assign prog_done = (state == SQ_PROG) && (tick == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      tick  <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (end_ev) begin
          state <= SQ_CLEAR;
          tick  <= '0;
        end
        SQ_CLEAR: begin
          state <= SQ_PROG;
          tick  <= tick + 1'b1;
        end
        SQ_PROG: begin
          if (prog_done) state <= SQ_IDLE;
          else           tick  <= tick + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SQ_IDLE);
  assign arr_we    = (state == SQ_CLEAR) || prog_done;
  assign arr_wdata = (state == SQ_CLEAR) ? '1 : lat_data;
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Storage is not reset: contents survive a reset of the engine.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvbyte_wr_engine.sv
module nvbyte_wr_engine #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WC_STD_CYC  = 50000,
  parameter int unsigned WC_FAST_CYC = 10000,
  parameter int unsigned POR_CYC     = 250000,
  parameter bit          FAST_SEL    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_ok,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              dat_oe,
  output logic              done_line,
  output logic              done_line_drv
);
  localparam int unsigned WC_CYC = nvw_pkg::pick_wc(WC_STD_CYC, WC_FAST_CYC, FAST_SEL);

  logic              wr_allow, busy, start_ev, end_ev, arr_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data, arr_wdata, arr_rdata;

  nvw_power #(.POR_CYC(POR_CYC)) u_power (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .wr_allow(wr_allow)
  );

  nvw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
    .addr_i(addr_i), .dat_i(dat_i), .wr_allow(wr_allow), .busy(busy),
    .start_ev(start_ev), .end_ev(end_ev), .lat_addr(lat_addr), .lat_data(lat_data)
  );

  nvw_seq #(.DATA_W(DATA_W), .WC_CYC(WC_CYC)) u_seq (
    .clk(clk), .rst(rst), .end_ev(end_ev), .lat_data(lat_data),
    .busy(busy), .arr_we(arr_we), .arr_wdata(arr_wdata)
  );

  nvw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(lat_addr), .wdata(arr_wdata),
    .raddr(addr_i), .rdata(arr_rdata)
  );

  assign dat_oe = nvw_pkg::rd_drive_on(cs_n, oe_n, wr_n);

  // While busy, every read is a poll: inverted top bit, lower bits zero.
  always_comb begin
    dat_o = '0;
    if (dat_oe) begin
      if (busy) dat_o[DATA_W-1] = ~lat_data[DATA_W-1];
      else      dat_o           = arr_rdata;
    end
  end

  assign done_line     = !busy;
  assign done_line_drv = busy;
endmodule

// File: rtl/nvw_chk.sv
module nvw_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WC_CYC = 50000
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_ok,
  input logic              cs_n,
  input logic              oe_n,
  input logic              wr_n,
  input logic              busy,
  input logic              start_ev,
  input logic              end_ev,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [DATA_W-1:0] lat_data,
  input logic [DATA_W-1:0] dat_o,
  input logic              dat_oe,
  input logic              done_line,
  input logic              done_line_drv
);
  localparam int unsigned RW = $clog2(WC_CYC + 1) + 1;

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  AST_BUSY_AFTER_END: assert property (@(posedge clk) disable iff (rst) end_ev |=> busy); // R2
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (run_cnt < RW'(WC_CYC))); // R3
  AST_RUN_EXACT: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (run_cnt == RW'(WC_CYC))); // R3
  AST_POLL_BIT: assert property (@(posedge clk) disable iff (rst) (busy && dat_oe) |-> (dat_o[DATA_W-1] != lat_data[DATA_W-1])); // R4
  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> (done_line && !done_line_drv)); // R6
  AST_NO_START_OE_LOW: assert property (@(posedge clk) disable iff (rst) !oe_n |-> !start_ev); // R7
  AST_NO_START_UNPOWERED: assert property (@(posedge clk) disable iff (rst) !pwr_ok |-> !start_ev); // R8
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst) dat_oe |-> (!cs_n && !oe_n && wr_n)); // R9
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data))); // R10
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !start_ev); // R10
endmodule

bind nvbyte_wr_engine nvw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WC_CYC(WC_CYC)) u_chk (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
  .busy(busy), .start_ev(start_ev), .end_ev(end_ev), .lat_addr(lat_addr),
  .lat_data(lat_data), .dat_o(dat_o), .dat_oe(dat_oe), .done_line(done_line),
  .done_line_drv(done_line_drv)
);

// File: tb/sim_nvbyte_wr_engine.sv
`timescale 1ns/1ps
module sim_nvbyte_wr_engine;
  localparam int WC_S = 40;
  localparam int WC_F = 12;
  localparam int POR  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1, pwr_ok = 1'b1, cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1;
  logic [5:0] addr_i = '0;
  logic [7:0] dat_i = '0;
  logic [7:0] d0_o, d1_o;
  logic d0_oe, d1_oe, l0, l0_drv, l1, l1_drv;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  nvbyte_wr_engine #(.ADDR_W(6), .DATA_W(8), .WC_STD_CYC(WC_S), .WC_FAST_CYC(WC_F),
                     .POR_CYC(POR), .FAST_SEL(1'b0)) u0 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
    .addr_i(addr_i), .dat_i(dat_i), .dat_o(d0_o), .dat_oe(d0_oe),
    .done_line(l0), .done_line_drv(l0_drv));

  nvbyte_wr_engine #(.ADDR_W(6), .DATA_W(8), .WC_STD_CYC(WC_S), .WC_FAST_CYC(WC_F),
                     .POR_CYC(POR), .FAST_SEL(1'b1)) u1 (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
    .addr_i(addr_i), .dat_i(dat_i), .dat_o(d1_o), .dat_oe(d1_oe),
    .done_line(l1), .done_line_drv(l1_drv));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; oe_n = 1'b1; wr_n = 1'b1;
  endtask

  // Pulse with junk data first, then move addr and settle data mid-pulse.
  // Returns right after the clock edge at which the pulse ends.
  task automatic strobe(input logic [5:0] a, input logic [7:0] d, input logic oe_lvl,
                        input logic cs_lvl);
    @(negedge clk); addr_i = a; dat_i = ~d; oe_n = oe_lvl; cs_n = cs_lvl; wr_n = 1'b1;
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); addr_i = ~a; dat_i = d;
    @(negedge clk); wr_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1; addr_i = a; #1;
    v = d0_o; oe = d0_oe;
  endtask

  task automatic expect_idle(input string tag, input int cycles);
    logic seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (l0_drv !== 1'b0 || l0 !== 1'b1) seen = 1'b1;
    end
    chk(tag, seen, 1'b0);
  endtask

  // Write and time it on both instances; poll during busy, read after.
  task automatic write_timed(input logic [5:0] a, input logic [7:0] d);
    int len0 = 0, len1 = 0;
    logic poll_bad = 1'b0, line_bad = 1'b0;
    strobe(a, d, 1'b1, 1'b0);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1; addr_i = a; #1;
    while (l0_drv === 1'b1 && len0 < 1000) begin
      len0++;
      if (l1_drv === 1'b1) len1++;
      if (l0 !== 1'b0) line_bad = 1'b1;
      if (d0_oe !== 1'b1 || d0_o !== {~d[7], 7'h00}) poll_bad = 1'b1;
      @(negedge clk); #1;
    end
    chk("R3 std busy length", len0, WC_S);
    chk("R3 fast busy length", len1, WC_F);
    chk("R4 poll word", poll_bad, 1'b0);
    chk("R6 line low while busy", line_bad, 1'b0);
    chk("R5 true data after busy", d0_o, d);
    chk("R6 line released", {l0, l0_drv}, 2'b10);
    idle_pins();
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_pins();
    repeat (3) @(negedge clk);
    rst = 1'b0; #1;
    chk("R11 reset line released", {l0, l0_drv}, 2'b10);
    chk("R9 no drive when deselected", d0_oe, 1'b0);
    repeat (POR + 3) @(negedge clk);
  endtask

  task automatic t_basic();
    logic [7:0] v; logic oe;
    write_timed(6'h10, 8'h5A);
    write_timed(6'h11, 8'hC3);
    rd(6'h10, v, oe);
    chk("R1 captured addr and data", v, 8'h5A);
    chk("R9 drive on read", oe, 1'b1);
    @(negedge clk); oe_n = 1'b1; #1;
    chk("R9 no drive with oe high", d0_oe, 1'b0);
    @(negedge clk); oe_n = 1'b0; wr_n = 1'b0; cs_n = 1'b1; #1;
    chk("R9 no drive with strobe low", d0_oe, 1'b0);
    idle_pins();
  endtask

  task automatic t_inhibit();
    logic [7:0] v; logic oe;
    strobe(6'h10, 8'h00, 1'b0, 1'b0);
    expect_idle("R7 oe low starts nothing", 4);
    idle_pins();
    strobe(6'h10, 8'h00, 1'b1, 1'b1);
    expect_idle("R7 cs high starts nothing", 4);
    rd(6'h10, v, oe);
    chk("R7 byte unchanged", v, 8'h5A);
    idle_pins();
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v; logic oe;
    int len = 0;
    write_timed(6'h21, 8'h44);
    strobe(6'h20, 8'h81, 1'b1, 1'b0);
    @(negedge clk); addr_i = 6'h21; dat_i = 8'h33; wr_n = 1'b0; #1;
    len++;
    repeat (3) begin @(negedge clk); #1; len++; end
    wr_n = 1'b1;
    while (l0_drv === 1'b1 && len < 1000) begin @(negedge clk); #1; len++; end
    chk("R10 busy not lengthened", len, WC_S + 1);
    idle_pins();
    rd(6'h20, v, oe);
    chk("R10 first write kept", v, 8'h81);
    rd(6'h21, v, oe);
    chk("R10 ignored write left byte", v, 8'h44);
    idle_pins();
  endtask

  task automatic t_power();
    logic [7:0] v; logic oe;
    write_timed(6'h30, 8'h11);
    @(negedge clk); pwr_ok = 1'b0;
    strobe(6'h30, 8'hEE, 1'b1, 1'b0);
    expect_idle("R8 no write when power low", 4);
    idle_pins();
    @(negedge clk); pwr_ok = 1'b1;
    strobe(6'h30, 8'hEE, 1'b1, 1'b0);
    expect_idle("R8 no write inside settle window", 4);
    rd(6'h30, v, oe);
    chk("R8 byte unchanged", v, 8'h11);
    idle_pins();
    repeat (POR + 3) @(negedge clk);
    write_timed(6'h30, 8'h6E);
  endtask

  task automatic t_reset_mid();
    logic [7:0] v; logic oe;
    write_timed(6'h3F, 8'h12);
    strobe(6'h3F, 8'h77, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    chk("R11 reset clears busy", {l0, l0_drv}, 2'b10);
    rd(6'h3F, v, oe);
    chk("R2 interrupted byte left erased", v, 8'hFF);
    rd(6'h10, v, oe);
    chk("R11 array kept over reset", v, 8'h5A);
    idle_pins();
    strobe(6'h3F, 8'h01, 1'b1, 1'b0);
    expect_idle("R11 settle window restarted", 4);
    idle_pins();
    repeat (POR + 3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=expired exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_inhibit();
    t_busy_ignore();
    t_power();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule